// File: doc/BRIEF.md
# Serial Flash Status Register Responder

This block is the device-side logic that answers status queries arriving over a mode 0 SPI link. Command bits on the data input are sampled on rising serial-clock edges while the active-low select is held low. Once the read-status opcode has arrived, the block presents the status byte on the serial output, most significant bit first, one bit per falling serial-clock edge. It keeps looping over the byte for as long as select stays low and the clock keeps running. Every pass starts from a fresh capture of the live status inputs.

The status byte combines internal conditions: busy, write-enable latch, the two-bit software protection state, the write-protect pin level, the program/erase error flag and the sequential-program flag. Its top bit is a lock flag held inside the block. A write-status opcode followed by one data byte loads that flag from the data byte's top bit. No other status bit can be written.

The serial pins are sampled by a faster system clock through a synchronizer. Each high phase and each low phase of the serial clock must last at least four system clocks. The output's high-impedance state is shown by `spiSoEn` being low, and the pad driver is expected to use it as its enable.

Top module: `spiStatusResponder`

## Requirements
- R1: After reset `spiSoEn` is 0 and `lockOut` is 0.
- R2: The opcode is sampled on rising `spiSck` edges while `spiCsN` is low, MSB first. The read opcode is 0x05. `spiSoEn` stays 0 while the opcode is shifted in.
- R3: The falling `spiSck` edge that follows the eighth opcode bit raises `spiSoEn` and drives status bit 7 on `spiSo`. Each later falling edge drives the next lower bit, and the bit is valid within four system clocks of that edge.
- R4: Status byte layout: bit 7 = lock flag, bit 6 = `seqModeIn`, bit 5 = `progErrIn`, bit 4 = `wpPinNIn` (0 = pin asserted, 1 = deasserted), bits 3:2 = `swProtIn` passed unchanged (00 none protected, 01 some, 10 reserved, 11 all), bit 1 = `welIn`, bit 0 = `busyIn`.
- R5: After bit 0 the stream restarts at bit 7. Each pass carries a snapshot taken on the falling edge that drives its bit 7. An input change later in that pass does not alter the pass.
- R6: Raising `spiCsN` at any bit position, including mid-byte, drops `spiSoEn` to 0. A following command is served normally.
- R7: Status can be read while `busyIn` is 1, with every software protection code.
- R8: Opcode 0x01 followed by eight data bits sets the lock flag to the data byte's bit 7. The flag is visible on `lockOut` and in status bit 7.
- R9: Any other opcode is ignored. `spiSoEn` stays 0 until `spiCsN` rises, and the lock flag is unchanged.
- R10: A write-status command cut off by `spiCsN` before its eighth data bit leaves the lock flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSck | input | 1 | Serial clock, idle low |
| spiCsN | input | 1 | Active-low select |
| spiSi | input | 1 | Serial data in |
| spiSo | output | 1 | Serial data out |
| spiSoEn | output | 1 | Output driver enable; 0 means high impedance |
| busyIn | input | 1 | Internal operation in progress |
| welIn | input | 1 | Write-enable latch state |
| swProtIn | input | 2 | Software protection state |
| wpPinNIn | input | 1 | Write-protect pin level |
| progErrIn | input | 1 | Program/erase error flag |
| seqModeIn | input | 1 | Sequential program mode flag |
| lockOut | output | 1 | Current lock flag |

## Verification
Reads run with random status inputs and a random number of repeated bytes. On some reads the inputs change halfway through a byte. This separates a design that recaptures status at each bit 7 from one that latches once per command, and from one that passes live inputs straight through and tears the byte. Aborts after a random number of bits check the output disable and recovery. Writes with random data, truncated writes and random non-supported opcodes tell a lock update apart from a spurious one, and a silent ignore apart from a driven output. Directed reads with busy held high sweep all four protection codes.

// File: rtl/spiStatusPkg.sv
package spiStatusPkg;
  localparam int STATUS_W = 8;
  localparam int BITCNT_W = $clog2(STATUS_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_WRDATA,
    ST_IGNORE
  } ctlState_t;

  typedef struct packed {
    logic sessionClr;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic lockWrite;
  } dpStrobe_t;
endpackage

// File: rtl/spiEdgeSync.sv
module spiEdgeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic si,
  output logic sckRise,
  output logic sckFall,
  output logic csActive,
  output logic siBit
);
  logic [STAGES-1:0] sckPipe;
  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] siPipe;
  logic sckLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;
      siPipe  <= '0;
      sckLast <= 1'b0;
    end else begin
      sckPipe <= {sckPipe[STAGES-2:0], sck};
      csPipe  <= {csPipe[STAGES-2:0], csN};
      siPipe  <= {siPipe[STAGES-2:0], si};
      sckLast <= sckPipe[STAGES-1];
    end
  end

  assign csActive = ~csPipe[STAGES-1];
  assign siBit    = siPipe[STAGES-1];
  assign sckRise  = csActive & sckPipe[STAGES-1] & ~sckLast;
  assign sckFall  = csActive & ~sckPipe[STAGES-1] & sckLast;
endmodule

// File: rtl/statusCtl.sv
module statusCtl
  import spiStatusPkg::*;
#(
  parameter logic [STATUS_W-1:0] RD_OPCODE = 8'h05,
  parameter logic [STATUS_W-1:0] WR_OPCODE = 8'h01
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csActive,
  input  logic                sckRise,
  input  logic                sckFall,
  input  logic                lastBit,
  input  logic                txAtStart,
  input  logic [STATUS_W-1:0] rxNext,
  output dpStrobe_t           strobe,
  output ctlState_t           ctlState
);
  ctlState_t nextState;
  logic byteDone;

  assign byteDone = sckRise & lastBit;

  always_comb begin
    strobe            = '0;
    strobe.sessionClr = ~csActive;
    nextState         = ctlState;
    if (!csActive) begin
      nextState = ST_IDLE;
    end else begin
      unique case (ctlState)
        ST_IDLE, ST_CMD: begin
          strobe.rxShift = sckRise;
          nextState      = ST_CMD;
          if (byteDone) begin
            if (rxNext == RD_OPCODE)      nextState = ST_READ;
            else if (rxNext == WR_OPCODE) nextState = ST_WRDATA;
            else                          nextState = ST_IGNORE;
          end
        end
        ST_READ: begin
          strobe.txLoad  = sckFall & txAtStart;
          strobe.txShift = sckFall & ~txAtStart;
        end
        ST_WRDATA: begin
          strobe.rxShift = sckRise;
          if (byteDone) begin
            strobe.lockWrite = 1'b1;
            nextState        = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlState <= ST_IDLE;
    else       ctlState <= nextState;
  end

  // the lock flag is only ever written from the write-data phase
  assert_lock_write_phase_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockWrite |=> (ctlState == ST_IGNORE));
endmodule

// File: rtl/statusDp.sv
module statusDp
  import spiStatusPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                siBit,
  input  logic [STATUS_W-2:0] liveStatus,
  output logic                lastBit,
  output logic                txAtStart,
  output logic [STATUS_W-1:0] rxNext,
  output logic                soBit,
  output logic                soEn,
  output logic                lockBit
);
  logic [BITCNT_W-1:0] bitCnt;
  logic [BITCNT_W-1:0] txCnt;
  logic [STATUS_W-1:0] rxReg;
  logic [STATUS_W-1:0] txReg;
  logic                txLast;

  assign lastBit   = (bitCnt == BITCNT_W'(STATUS_W - 1));
  assign txLast    = (txCnt == BITCNT_W'(STATUS_W - 1));
  assign txAtStart = (txCnt == '0);
  assign rxNext    = {rxReg[STATUS_W-2:0], siBit};
  assign soBit     = txReg[STATUS_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      txCnt   <= '0;
      rxReg   <= '0;
      txReg   <= '0;
      soEn    <= 1'b0;
      lockBit <= 1'b0;
    end else begin
      if (strobe.sessionClr) begin
        bitCnt <= '0;
        txCnt  <= '0;
        soEn   <= 1'b0;
      end else begin
        if (strobe.rxShift) begin
          rxReg  <= rxNext;
          bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
        end
        if (strobe.txLoad) begin
          txReg <= {lockBit, liveStatus};
          txCnt <= BITCNT_W'(1);
          soEn  <= 1'b1;
        end else if (strobe.txShift) begin
          txReg <= {txReg[STATUS_W-2:0], 1'b0};
          txCnt <= txLast ? '0 : txCnt + 1'b1;
        end
      end
      if (strobe.lockWrite) lockBit <= rxNext[STATUS_W-1];
    end
  end

  // receive and transmit never act in the same cycle
  assert_single_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rxShift, strobe.txLoad, strobe.txShift}));

  // a snapshot is captured only at a byte boundary of the output stream
  assert_snapshot_at_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad |=> (txCnt == BITCNT_W'(1)) && soEn);
endmodule

// File: rtl/spiStatusResponder.sv
module spiStatusResponder
  import spiStatusPkg::*;
#(
  parameter int                  SYNC_STAGES = 2,
  parameter logic [STATUS_W-1:0] RD_OPCODE   = 8'h05,
  parameter logic [STATUS_W-1:0] WR_OPCODE   = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSck,
  input  logic       spiCsN,
  input  logic       spiSi,
  output logic       spiSo,
  output logic       spiSoEn,
  input  logic       busyIn,
  input  logic       welIn,
  input  logic [1:0] swProtIn,
  input  logic       wpPinNIn,
  input  logic       progErrIn,
  input  logic       seqModeIn,
  output logic       lockOut
);
  logic sckRise, sckFall, csActive, siBit;
  logic lastBit, txAtStart, soBit, soEn;
  logic [STATUS_W-1:0] rxNext;
  logic [STATUS_W-2:0] liveStatus;
  dpStrobe_t strobe;
  ctlState_t ctlState;

  assign liveStatus = {seqModeIn, progErrIn, wpPinNIn, swProtIn, welIn, busyIn};

  spiEdgeSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sck(spiSck), .csN(spiCsN), .si(spiSi),
    .sckRise(sckRise), .sckFall(sckFall), .csActive(csActive), .siBit(siBit)
  );

  statusCtl #(.RD_OPCODE(RD_OPCODE), .WR_OPCODE(WR_OPCODE)) u_ctl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .sckRise(sckRise),
    .sckFall(sckFall), .lastBit(lastBit), .txAtStart(txAtStart),
    .rxNext(rxNext), .strobe(strobe), .ctlState(ctlState)
  );

  statusDp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .siBit(siBit),
    .liveStatus(liveStatus), .lastBit(lastBit), .txAtStart(txAtStart),
    .rxNext(rxNext), .soBit(soBit), .soEn(soEn), .lockBit(lockOut)
  );

  assign spiSoEn = soEn;
  assign spiSo   = soEn ? soBit : 1'b0;

  // deselect always releases the output
  assert_release_on_deselect_R6: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !spiSoEn);

  // output is driven only while serving a read
  assert_quiet_outside_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState != ST_READ) |-> !spiSoEn);

  // output data moves only after a falling serial edge
  assert_bit_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sckFall |=> $stable(soBit));

  // lock flag changes only after the write-data phase
  assert_lock_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockOut) |-> ($past(ctlState) == ST_WRDATA));
endmodule

// File: tb/spiStatusResponder_bench.sv
module spiStatusResponder_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, spiSck, spiCsN, spiSi, spiSo, spiSoEn;
  logic busyIn, welIn, wpPinNIn, progErrIn, seqModeIn, lockOut;
  logic [1:0] swProtIn;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic lockModel = 1'b0;

  localparam logic [7:0] OP_RD = 8'h05;
  localparam logic [7:0] OP_WR = 8'h01;

  spiStatusResponder u_spiStatusResponder (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiSi(spiSi),
    .spiSo(spiSo), .spiSoEn(spiSoEn), .busyIn(busyIn), .welIn(welIn),
    .swProtIn(swProtIn), .wpPinNIn(wpPinNIn), .progErrIn(progErrIn),
    .seqModeIn(seqModeIn), .lockOut(lockOut)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expStatus();
    return {lockModel, seqModeIn, progErrIn, wpPinNIn, swProtIn, welIn, busyIn};
  endfunction

  task automatic randStatus();
    logic [6:0] r;
    r = 7'($urandom);
    {seqModeIn, progErrIn, wpPinNIn, swProtIn, welIn, busyIn} = r;
  endtask

  task automatic sckBit(input logic b, output logic so, output logic en);
    spiSi = b;
    waitClk(3);
    spiSck = 1'b1;
    waitClk(6);
    spiSck = 1'b0;
    waitClk(4);
    so = spiSo;
    en = spiSoEn;
  endtask

  task automatic selectDev();
    spiCsN = 1'b0;
    waitClk(4);
  endtask

  task automatic deselect(input string req);
    spiCsN = 1'b1;
    spiSi  = 1'b0;
    waitClk(6);
    check(req, "enable after deselect", {7'd0, spiSoEn}, 8'd0);
  endtask

  // shifts nBits of val MSB first, counting cycles where the output was enabled
  task automatic shiftQuiet(input logic [7:0] val, input int nBits, inout int drv);
    logic so, en;
    for (int i = 7; i > 7 - nBits; i--) begin
      sckBit(val[i], so, en);
      if (en) drv++;
    end
  endtask

  task automatic doRead(input int nBytes, input bit midChange, input int cutBits,
                        input string req);
    logic so, en;
    logic [7:0] got, exp, enMask;
    int drv = 0;
    selectDev();
    shiftQuiet(OP_RD, 7, drv);
    for (int b = 0; b < nBytes; b++) begin
      exp = expStatus();
      got = '0;
      enMask = '0;
      for (int k = 7; k >= 0; k--) begin
        if (cutBits > 0 && b == nBytes - 1 && k == 7 - cutBits) break;
        sckBit((b == 0 && k == 7) ? OP_RD[0] : 1'($urandom), so, en);
        got[k] = so;
        enMask[k] = en;
        if (midChange && k == 4) randStatus();
      end
      if (cutBits > 0 && b == nBytes - 1) begin
        got = got >> (8 - cutBits);
        exp = exp >> (8 - cutBits);
        enMask = enMask >> (8 - cutBits);
        check("R6", "partial byte bits", got, exp);
        check("R3", "partial enable", enMask, 8'((1 << cutBits) - 1));
      end else begin
        check(req, $sformatf("status byte %0d", b), got, exp);
        check("R3", "enable each bit", enMask, 8'hFF);
      end
    end
    check("R2", "enable during opcode", 8'(drv), 8'd0);
    deselect("R6");
  endtask

  task automatic doWrite(input logic [7:0] data, input int dataBits, input string req);
    int drv = 0;
    selectDev();
    shiftQuiet(OP_WR, 8, drv);
    shiftQuiet(data, dataBits, drv);
    deselect(req);
    if (dataBits == 8) lockModel = data[7];
    check(req, "lock flag", {7'd0, lockOut}, {7'd0, lockModel});
    check(req, "enable during write", 8'(drv), 8'd0);
  endtask

  task automatic doUnknown(input logic [7:0] op);
    int drv = 0;
    selectDev();
    shiftQuiet(op, 8, drv);
    shiftQuiet(8'($urandom), 8, drv);
    shiftQuiet(8'($urandom), 8, drv);
    check("R9", "enable after unknown opcode", 8'(drv), 8'd0);
    deselect("R9");
    check("R9", "lock after unknown opcode", {7'd0, lockOut}, {7'd0, lockModel});
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'd4242));
    rstN = 1'b0; spiSck = 1'b0; spiCsN = 1'b1; spiSi = 1'b0;
    {seqModeIn, progErrIn, wpPinNIn, swProtIn, welIn, busyIn} = 7'b0011100;
    waitClk(5);
    check("R1", "enable in reset", {7'd0, spiSoEn}, 8'd0);
    rstN = 1'b1;
    waitClk(5);
    check("R1", "enable after reset", {7'd0, spiSoEn}, 8'd0);
    check("R1", "lock after reset", {7'd0, lockOut}, 8'd0);

    // directed: every protection code while busy
    for (int c = 0; c < 4; c++) begin
      busyIn = 1'b1;
      swProtIn = 2'(c);
      doRead(1, 1'b0, 0, "R7");
    end
    // directed: layout with single bits set
    for (int i = 0; i < 7; i++) begin
      {seqModeIn, progErrIn, wpPinNIn, swProtIn, welIn, busyIn} = 7'(1 << i);
      doRead(1, 1'b0, 0, "R4");
    end
    // directed: lock set then cleared, truncated write, repeat with mid-byte change
    doWrite(8'h80, 8, "R8");
    doRead(2, 1'b0, 0, "R8");
    doWrite(8'h7F, 5, "R10");
    doRead(1, 1'b0, 0, "R10");
    doWrite(8'h7F, 8, "R8");
    doRead(3, 1'b1, 0, "R5");
    doUnknown(8'h06);
    doRead(1, 1'b0, 3, "R6");
    doRead(1, 1'b0, 0, "R6");

    // constrained random mix
    for (int t = 0; t < 50; t++) begin
      randStatus();
      case ($urandom_range(0, 4))
        0: doRead(1 + $urandom_range(0, 2), 1'b0, 0, "R4");
        1: doRead(2 + $urandom_range(0, 1), 1'b1, 0, "R5");
        2: doRead(1 + $urandom_range(0, 1), 1'b0, $urandom_range(1, 7), "R6");
        3: begin
          if ($urandom_range(0, 1) == 1) doWrite(8'($urandom), 8, "R8");
          else doWrite(8'($urandom), $urandom_range(0, 7), "R10");
        end
        default: begin
          do op = 8'($urandom); while (op == OP_RD || op == OP_WR);
          doUnknown(op);
        end
      endcase
    end

    finished = 1'b1;
    report();
    $finish;
  end
endmodule